// File: doc/BRIEF.md
# Timer Compare Match Flag Unit

This block watches a free-running timer count that is kept elsewhere and compares it on every clock cycle against a programmable compare value. When the two are equal, a match is not posted at once. It is posted on the timer tick, which is a single-cycle enable from the prescaler. The flag therefore rises one timer clock after equality is first seen. A raised flag can be turned into an interrupt request, and it is cleared either by the interrupt acknowledge or by a software clear strobe.

Each equality event is flagged once. If the timer stalls while ticks keep arriving and the count stays equal to the compare value, no further matches are posted. Detection is re-armed in two cases: when the count moves off the compare value, or when the compare register is written. A parameter selects a variant that posts on every tick while the values are equal.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, flag_o and irq_o are 0 and the compare register holds CMP_RESET (default 0).
- R2: A cycle with cmp_wr_i high loads cmp_wdata_i into the compare register. The new value is used for comparison from the following cycle onward; in the write cycle itself the old value is still compared.
- R3: On a cycle where tick_i is 1, count_i equals the compare register, and the current equality event has not yet been flagged, flag_o is 1 from the next cycle.
- R4: Equality without tick_i never sets flag_o, however many cycles it lasts.
- R5: irq_o is 1 exactly when flag_o is 1 and irq_en_i is 1, in the same cycle without delay.
- R6: irq_ack_i high for one cycle clears flag_o from the next cycle.
- R7: flag_clr_i high for one cycle clears flag_o from the next cycle.
- R8: When a match is posted in the same cycle as irq_ack_i or flag_clr_i, flag_o is 1 in the next cycle, because the set takes priority.
- R9: With the default ONE_SHOT=1, further ticks do not set the flag again while count_i stays equal to the compare value. Once count_i differs from it on any cycle, the next equal tick posts again.
- R10: A compare write re-arms detection. After a write of the value already held, a tick with count_i equal posts a match again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W | Current timer count |
| tick_i | input | 1 | Timer clock enable, one cycle wide |
| cmp_wr_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | CNT_W | Compare register write data |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Interrupt serviced; clears the flag |
| flag_clr_i | input | 1 | Software write-one clear of the flag |
| flag_o | output | 1 | Match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A 4-bit configuration is swept over every pair of compare value and count, with one tick per pair. This separates true equality from off-by-one and bit-slice errors in the comparator, and the interrupt enable is toggled across the sweep. Directed sequences hold equality without ticks, then with repeated ticks on a stalled count. These runs show whether posting is gated by the tick and whether it happens only once per event. Writes of the same compare value, and clears that coincide with a set, separate re-arm and priority faults from plain flag errors.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
   parameter int unsigned OCMP_MAX_W = 64;

   typedef struct packed {
      logic set;
      logic ack;
      logic clr;
   } flag_ctl_t;
endpackage

// File: rtl/ocmp_cmp_reg.sv
module ocmp_cmp_reg #(
   parameter int unsigned CNT_W     = 16,
   parameter logic [CNT_W-1:0] CMP_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] value_o
);
   logic [CNT_W-1:0] value_q;

   always_ff @(posedge clk) begin
      if (!rst_n) value_q <= CMP_RESET;
      else if (wr_i) value_q <= wdata_i;
   end

   assign value_o = value_q;
endmodule

// File: rtl/ocmp_eq_detect.sv
module ocmp_eq_detect #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          ONE_SHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             tick_i,
   input  logic             rearm_i,
   output logic             post_o
);
   logic equal_w;

   assign equal_w = (count_i == cmp_i);

   generate
      if (ONE_SHOT) begin : g_once
         logic served_q;
         logic post_w;

         assign post_w = tick_i & equal_w & ~served_q;

         always_ff @(posedge clk) begin
            if (!rst_n)        served_q <= 1'b0;
            else if (rearm_i)  served_q <= 1'b0;
            else if (!equal_w) served_q <= 1'b0;
            else if (post_w)   served_q <= 1'b1;
         end

         assign post_o = post_w;
      end else begin : g_every
         logic unused_w;
         assign unused_w = clk ^ rst_n ^ rearm_i;
         assign post_o   = tick_i & equal_w;
      end
   endgenerate
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag
   import ocmp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  flag_ctl_t ctl_i,
   input  logic      irq_en_i,
   output logic      flag_o,
   output logic      irq_o
);
   logic flag_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (ctl_i.set)                    flag_d = 1'b1;
      else if (ctl_i.ack || ctl_i.clr)  flag_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
   import ocmp_pkg::*;
#(
   parameter int unsigned      CNT_W     = 16,
   parameter bit               ONE_SHOT  = 1'b1,
   parameter logic [CNT_W-1:0] CMP_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             tick_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_wdata_i,
   input  logic             irq_en_i,
   input  logic             irq_ack_i,
   input  logic             flag_clr_i,
   output logic             flag_o,
   output logic             irq_o
);
   generate
      if (CNT_W < 1 || CNT_W > OCMP_MAX_W) begin : g_bad_width
         $error("ocmp_unit: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_w;
   logic             post_w;
   flag_ctl_t        ctl_w;

   ocmp_cmp_reg #(
      .CNT_W     (CNT_W),
      .CMP_RESET (CMP_RESET)
   ) cmp_reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cmp_wr_i),
      .wdata_i (cmp_wdata_i),
      .value_o (cmp_w)
   );

   ocmp_eq_detect #(
      .CNT_W    (CNT_W),
      .ONE_SHOT (ONE_SHOT)
   ) eq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (count_i),
      .cmp_i   (cmp_w),
      .tick_i  (tick_i),
      .rearm_i (cmp_wr_i),
      .post_o  (post_w)
   );

   assign ctl_w.set = post_w;
   assign ctl_w.ack = irq_ack_i;
   assign ctl_w.clr = flag_clr_i;

   ocmp_flag flag_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_i    (ctl_w),
      .irq_en_i (irq_en_i),
      .flag_o   (flag_o),
      .irq_o    (irq_o)
   );
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          ONE_SHOT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_i,
   input logic             tick_i,
   input logic             cmp_wr_i,
   input logic [CNT_W-1:0] cmp_wdata_i,
   input logic             irq_ack_i,
   input logic             flag_clr_i,
   input logic             flag_o,
   input logic             post,
   input logic [CNT_W-1:0] cmp_q
);
   p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr_i |=> (cmp_q == $past(cmp_wdata_i)));

   p_post_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      post |=> flag_o);

   p_set_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(tick_i));

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !post) |=> !flag_o);

   p_sw_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !post) |=> !flag_o);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (post && (irq_ack_i || flag_clr_i)) |=> flag_o);

   generate
      if (ONE_SHOT) begin : g_once_chk
         p_no_repost_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (post && !cmp_wr_i) |=> (!$stable(count_i) || !post));
      end
   endgenerate
endmodule

bind ocmp_unit ocmp_unit_chk #(
   .CNT_W    (CNT_W),
   .ONE_SHOT (ONE_SHOT)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .count_i     (count_i),
   .tick_i      (tick_i),
   .cmp_wr_i    (cmp_wr_i),
   .cmp_wdata_i (cmp_wdata_i),
   .irq_ack_i   (irq_ack_i),
   .flag_clr_i  (flag_clr_i),
   .flag_o      (flag_o),
   .post        (post_w),
   .cmp_q       (cmp_w)
);

// File: tb/ocmp_unit_tb.sv
module ocmp_unit_tb_top;
   localparam int unsigned W = 4;
   localparam int unsigned N = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] count_i;
   logic         tick_i;
   logic         cmp_wr_i;
   logic [W-1:0] cmp_wdata_i;
   logic         irq_en_i;
   logic         irq_ack_i;
   logic         flag_clr_i;
   logic         flag_o;
   logic         irq_o;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ocmp_unit #(.CNT_W(W), .ONE_SHOT(1'b1), .CMP_RESET('0)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .count_i     (count_i),
      .tick_i      (tick_i),
      .cmp_wr_i    (cmp_wr_i),
      .cmp_wdata_i (cmp_wdata_i),
      .irq_en_i    (irq_en_i),
      .irq_ack_i   (irq_ack_i),
      .flag_clr_i  (flag_clr_i),
      .flag_o      (flag_o),
      .irq_o       (irq_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not end, got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; count_i = '0; tick_i = 1'b0; cmp_wr_i = 1'b0;
      cmp_wdata_i = '0; irq_en_i = 1'b0; irq_ack_i = 1'b0; flag_clr_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 flag after reset", flag_o, 1'b0);
      chk("R1 irq after reset", irq_o, 1'b0);

      // equality (count 0, reset compare 0) without ticks
      step(); step(); step();
      chk("R4 no tick no flag", flag_o, 1'b0);

      tick_i = 1'b1; step(); tick_i = 1'b0; #1;
      chk("R3 R1 tick on reset compare posts", flag_o, 1'b1);
      chk("R5 irq masked", irq_o, 1'b0);
      irq_en_i = 1'b1; #1;
      chk("R5 irq enabled", irq_o, 1'b1);

      irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0; #1;
      chk("R6 ack clears", flag_o, 1'b0);
      chk("R5 irq drops with flag", irq_o, 1'b0);

      // stalled count, ticks keep coming
      tick_i = 1'b1; step(); step(); step(); #1;
      chk("R9 no repost while equal", flag_o, 1'b0);
      count_i = 4'd1; step();
      count_i = 4'd0; step(); tick_i = 1'b0; #1;
      chk("R9 rearm after leaving equality", flag_o, 1'b1);

      flag_clr_i = 1'b1; step(); flag_clr_i = 1'b0; #1;
      chk("R7 sw clear", flag_o, 1'b0);

      // same-value write re-arms
      cmp_wr_i = 1'b1; cmp_wdata_i = 4'd0; step(); cmp_wr_i = 1'b0; #1;
      chk("R10 write alone no flag", flag_o, 1'b0);
      tick_i = 1'b1; step(); tick_i = 1'b0; #1;
      chk("R10 write rearms", flag_o, 1'b1);

      flag_clr_i = 1'b1; step(); flag_clr_i = 1'b0;
      // write 5 with count 5 and tick in same cycle: old compare used
      count_i = 4'd5; cmp_wr_i = 1'b1; cmp_wdata_i = 4'd5; tick_i = 1'b1;
      step(); cmp_wr_i = 1'b0; #1;
      chk("R2 old compare in write cycle", flag_o, 1'b0);
      irq_ack_i = 1'b1; flag_clr_i = 1'b1;
      step(); irq_ack_i = 1'b0; flag_clr_i = 1'b0; tick_i = 1'b0; #1;
      chk("R2 R8 new compare posts, set wins", flag_o, 1'b1);

      // exhaustive sweep of compare x count
      for (int c = 0; c < N; c++) begin
         for (int k = 0; k < N; k++) begin
            cmp_wr_i = 1'b1; cmp_wdata_i = W'(c); flag_clr_i = 1'b1;
            count_i = W'(k); irq_en_i = c[0];
            step();
            cmp_wr_i = 1'b0; flag_clr_i = 1'b0; tick_i = 1'b1;
            step();
            tick_i = 1'b0; #1;
            chk("R3 sweep flag", flag_o, (c == k));
            chk("R5 sweep irq", irq_o, (c == k) && c[0]);
         end
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule